// File: doc/BRIEF.md
# Burst Register Access Controller

This block sits between a byte-wide serial command link and a small bank of byte registers. A frame opens with a command byte. That byte gives the direction of the transfer, a starting address and a short byte count. The controller then moves that many data bytes. After each byte it steps its internal address, and it wraps back to address 0 once it passes the highest register that actually exists. A frame-select input frames each transaction. Dropping it at any point abandons the transfer, and the next byte is taken as a new command.

Each register bit has an access type, and the controller enforces it on every byte:

- **Ordinary bits** store what is written.
- **Read-only bits** ignore writes.
- **Status bits** are set by hardware events. They report their value and are cleared at the end of any byte that touches them.
- **Second-bank mirror bits** return the value of a first-bank register. One mirror also clears its source when it is accessed.

A received-signal-strength register holds two 4-bit conversion results and can only be loaded from hardware.

The map has 14 implemented registers at addresses 0 to 13 in a 32-byte space:

| Address | Contents |
|---|---|
| 0–2, 4–7, 10, 11, 13 | Plain read/write |
| 3 | Bits 7:4 read/write; bits 3:0 are status bits |
| 8 | Read-only mirror of register 0 |
| 9 | Bits 7:4 read/write; bits 3:0 mirror register 3 bits 3:0 and clear them on access |
| 12 | Read-only strength register |

Top module: `regbank_ctrl`

## Requirements
- R1: The command byte carries the read flag in bit 7 (1 = read, 0 = write), the count N in bits 6:5 and the base address in bits 4:0. Exactly N+1 data bytes follow. Any further bytes in the same frame are ignored.
- R2: The internal address starts at the base address and advances by one after every data byte.
- R3: After address 13 the next address is 0. An unimplemented address (14 to 31) reads as 0, ignores writes and is also followed by address 0.
- R4: All registers reset to 0. On a write, read/write bits take the data byte. A read returns the stored value.
- R5: Register 12 ignores all writes. It loads the 8-bit strength input when the load strobe is high: bits 7:4 hold one conversion result and bits 3:0 hold the other. Register 8 also ignores writes.
- R6: Register 3 bits 3:0 are set by the event inputs and cannot be set by a write. They read back their current value and are cleared at the end of any read or write byte at address 3. Register 3 bits 7:4 are read/write.
- R7: Register 8 reads as the value of register 0. Register 9 bits 3:0 read as register 3 bits 3:0, and any read or write byte at address 9 clears register 3 bits 3:0. Register 9 bits 7:4 are read/write.
- R8: When an event sets a status bit in the same cycle that an access clears that bit, the bit ends up set.
- R9: Deasserting frame select ends the transaction immediately. The first byte after frame select is reasserted is decoded as a command.
- R10: During the data phase of a read, the read-data output shows the view of the current address before that byte's strobe. Outside a read data phase it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel | input | 1 | High for the duration of a transaction |
| rx_valid | input | 1 | One-cycle strobe marking a completed byte |
| rx_byte | input | 8 | Byte received from the link (command or write data) |
| evt_set | input | 4 | Event pulses that set register 3 bits 3:0 |
| rssi_ld | input | 1 | Load strobe for the strength register |
| rssi_in | input | 8 | Two 4-bit conversion results (bits 7:4 and 3:0) |
| rd_data | output | 8 | Byte to send back during a read |

## Verification
Two functions can meet in one cycle: a hardware event setting a status bit, and a read or write byte that clears the same bit, either directly at address 3 or through the mirror at address 9. The bench provokes this by driving an event pulse on the same edge as a data-byte strobe at those addresses. It then judges the outcome in two steps. It first checks the value returned for that byte. It then reads the register again and checks that the new event survived while the older bits were cleared. An assertion checks the same set-over-clear priority cycle by cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int NREGS     = 14;
  localparam int LAST      = NREGS - 1;
  localparam int IDX_W     = $clog2(NREGS);
  localparam int STAT_ADDR = 3;
  localparam int MIRA_ADDR = 8;
  localparam int MIRB_ADDR = 9;
  localparam int RSSI_ADDR = 12;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  function automatic logic implemented(addr_t a);
    return int'(a) < NREGS;
  endfunction

  function automatic addr_t next_addr(addr_t a);
    return (int'(a) >= LAST) ? addr_t'(0) : addr_t'(a + addr_t'(1));
  endfunction

  function automatic byte_t ro_mask(addr_t a);
    return (int'(a) == RSSI_ADDR) ? 8'hFF : 8'h00;
  endfunction

  function automatic byte_t rc_mask(addr_t a);
    return (int'(a) == STAT_ADDR) ? 8'h0F : 8'h00;
  endfunction

  function automatic byte_t mir_mask(addr_t a);
    if (int'(a) == MIRA_ADDR) return 8'hFF;
    if (int'(a) == MIRB_ADDR) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic addr_t mir_src(addr_t a);
    return (int'(a) == MIRB_ADDR) ? addr_t'(STAT_ADDR) : addr_t'(0);
  endfunction

  function automatic byte_t mirclr_mask(addr_t a);
    return (int'(a) == MIRB_ADDR) ? 8'h0F : 8'h00;
  endfunction

  function automatic byte_t wr_mask(addr_t a);
    if (!implemented(a)) return 8'h00;
    return ~(ro_mask(a) | rc_mask(a) | mir_mask(a));
  endfunction
endpackage

// File: rtl/regbank_seq.sv
module regbank_seq
  import regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_sel,
  input  logic  rx_valid,
  input  byte_t rx_byte,
  output logic  fire,
  output logic  is_rd,
  output addr_t addr,
  output logic  in_data,
  output logic  done
);
  typedef enum logic [1:0] {S_CMD, S_DATA, S_DONE} seq_st_t;

  seq_st_t    st;
  logic [1:0] left;

  assign fire    = frame_sel && rx_valid && (st == S_DATA);
  assign in_data = (st == S_DATA);
  assign done    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_CMD;
      addr  <= '0;
      is_rd <= 1'b0;
      left  <= '0;
    end else if (!frame_sel) begin
      st <= S_CMD;
    end else if (rx_valid) begin
      case (st)
        S_CMD: begin
          is_rd <= rx_byte[7];
          left  <= rx_byte[6:5];
          addr  <= rx_byte[ADDR_W-1:0];
          st    <= S_DATA;
        end
        S_DATA: begin
          addr <= next_addr(addr);
          if (left == 2'd0) st <= S_DONE;
          else              left <= left - 2'd1;
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       wr,
  input  addr_t      addr,
  input  byte_t      wdata,
  input  logic [3:0] evt_set,
  input  logic       rssi_ld,
  input  byte_t      rssi_in,
  output byte_t      view,
  output logic [3:0] stat_q,
  output byte_t      rssi_q,
  output logic       clr_pulse
);
  byte_t q [NREGS];
  addr_t src;
  logic  hit;

  assign hit       = implemented(addr);
  assign src       = mir_src(addr);
  assign clr_pulse = fire && ((rc_mask(addr) | mirclr_mask(addr)) != 8'h00);
  assign stat_q    = q[STAT_ADDR][3:0];
  assign rssi_q    = q[RSSI_ADDR];

  always_comb begin
    view = 8'h00;
    if (hit)
      view = (q[addr[IDX_W-1:0]] & ~mir_mask(addr)) |
             (q[src[IDX_W-1:0]] & mir_mask(addr));
  end

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    byte_t nx;
    always_comb begin
      nx = q[gi];
      if (fire && addr == addr_t'(gi)) begin
        if (wr) nx = (nx & ~wr_mask(addr)) | (wdata & wr_mask(addr));
        nx = nx & ~rc_mask(addr);
      end
      if (fire && hit && src == addr_t'(gi))
        nx = nx & ~mirclr_mask(addr);
      if (gi == STAT_ADDR)
        nx[3:0] = nx[3:0] | evt_set;
      if (gi == RSSI_ADDR && rssi_ld)
        nx = rssi_in;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[gi] <= 8'h00;
      else        q[gi] <= nx;
    end
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sel,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic [3:0] evt_set,
  input  logic       rssi_ld,
  input  logic [7:0] rssi_in,
  output logic [7:0] rd_data
);
  logic       acc_fire;
  logic       acc_rd;
  addr_t      acc_addr;
  logic       in_data;
  logic       burst_done;
  byte_t      view;
  logic [3:0] stat_q;
  byte_t      rssi_q;
  logic       clr_pulse;

  regbank_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fire(acc_fire), .is_rd(acc_rd), .addr(acc_addr),
    .in_data(in_data), .done(burst_done)
  );

  regbank_store u_store (
    .clk(clk), .rst_n(rst_n), .fire(acc_fire), .wr(!acc_rd),
    .addr(acc_addr), .wdata(rx_byte), .evt_set(evt_set),
    .rssi_ld(rssi_ld), .rssi_in(rssi_in), .view(view),
    .stat_q(stat_q), .rssi_q(rssi_q), .clr_pulse(clr_pulse)
  );

  assign rd_data = (in_data && acc_rd) ? view : 8'h00;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sel,
  input logic       fire,
  input logic       rd,
  input addr_t      addr,
  input logic       in_data,
  input logic       done,
  input logic [3:0] evt_set,
  input logic [3:0] stat_q,
  input byte_t      rssi_q,
  input logic       rssi_ld,
  input logic       clr_pulse,
  input byte_t      rd_data
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(addr) < LAST) |=> addr == $past(addr) + addr_t'(1)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(addr) >= LAST) |=> addr == addr_t'(0)); // R3
  AST_BURST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fire); // R1
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rssi_ld |=> $stable(rssi_q)); // R5
  AST_RC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && evt_set == 4'h0) |=> stat_q == 4'h0); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 4'h0) |=> (stat_q & $past(evt_set)) == $past(evt_set)); // R8
  AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sel |=> !in_data); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_data && rd) |-> rd_data == 8'h00); // R10
endmodule

bind regbank_ctrl regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel), .fire(acc_fire),
  .rd(acc_rd), .addr(acc_addr), .in_data(in_data), .done(burst_done),
  .evt_set(evt_set), .stat_q(stat_q), .rssi_q(rssi_q),
  .rssi_ld(rssi_ld), .clr_pulse(clr_pulse), .rd_data(rd_data)
);

// File: tb/tb_regbank_ctrl.sv
module tb_regbank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NIMP = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sel = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [3:0] evt_set = 4'h0;
  logic       rssi_ld = 1'b0;
  logic [7:0] rssi_in = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  logic [7:0] m [32];

  regbank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .evt_set(evt_set), .rssi_ld(rssi_ld),
    .rssi_in(rssi_in), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] step(logic [4:0] a);
    return (a >= 5'd13) ? 5'd0 : a + 5'd1;
  endfunction

  function automatic logic [7:0] wmask(logic [4:0] a);
    case (a)
      5'd3, 5'd9:   return 8'hF0;
      5'd8, 5'd12:  return 8'h00;
      default:      return (a < 5'(NIMP)) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expv(logic [4:0] a);
    if (a == 5'd8) return m[0];
    if (a == 5'd9) return {m[9][7:4], m[3][3:0]};
    if (a < 5'(NIMP)) return m[a];
    return 8'h00;
  endfunction

  task automatic mdl_acc(logic [4:0] a, bit wr, logic [7:0] d, logic [3:0] e);
    if (wr) m[a] = (m[a] & ~wmask(a)) | (d & wmask(a));
    if (a == 5'd3 || a == 5'd9) m[3][3:0] = 4'h0;
    m[3][3:0] = m[3][3:0] | e;
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(logic [7:0] b, logic [3:0] e);
    rx_valid = 1'b1; rx_byte = b; evt_set = e;
    @(negedge clk);
    rx_valid = 1'b0; evt_set = 4'h0;
  endtask

  task automatic open_frame(bit rd, logic [1:0] n, logic [4:0] a);
    frame_sel = 1'b1;
    @(negedge clk);
    xfer({rd, n, a}, 4'h0);
  endtask

  task automatic close_frame();
    frame_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_burst(logic [4:0] a0, logic [1:0] n, string tag);
    logic [4:0] a = a0;
    open_frame(1'b1, n, a0);
    for (int i = 0; i <= int'(n); i++) begin
      check(tag, rd_data, expv(a));
      xfer(8'h00, 4'h0);
      mdl_acc(a, 1'b0, 8'h00, 4'h0);
      a = step(a);
    end
    close_frame();
  endtask

  task automatic pulse_evt(logic [3:0] e);
    evt_set = e;
    @(negedge clk);
    evt_set = 4'h0;
    m[3][3:0] = m[3][3:0] | e;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired got 00 expected 01");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state, R10 idle output
    check("R10 idle rd_data", rd_data, 8'h00);
    for (int b = 0; b < 32; b += 4) rd_burst(5'(b), 2'd3, "R4 reset read");

    // R1 R2 R3 write sweep, every base address and all burst lengths
    for (int b = 0; b < 32; b++) begin
      logic [4:0] a = 5'(b);
      open_frame(1'b0, 2'(b % 4), 5'(b));
      for (int i = 0; i <= b % 4; i++) begin
        logic [7:0] d = 8'(b * 37 + i * 11 + 5);
        xfer(d, 4'h0);
        mdl_acc(a, 1'b1, d, 4'h0);
        a = step(a);
      end
      close_frame();
    end
    // R2 R3 R4 R5 R7 read sweep with wrap
    for (int b = 0; b < 32; b++) rd_burst(5'(b), 2'd3, "R2 R3 R4 sweep read");

    // R5 strength register load and write immunity
    rssi_ld = 1'b1; rssi_in = 8'hA5;
    @(negedge clk);
    rssi_ld = 1'b0; m[12] = 8'hA5;
    open_frame(1'b0, 2'd0, 5'd12); xfer(8'h3C, 4'h0); close_frame();
    rd_burst(5'd12, 2'd0, "R5 rssi read-only");
    check("R5 rssi value", m[12], 8'hA5);

    // R6 status read then clear
    pulse_evt(4'h5);
    open_frame(1'b1, 2'd1, 5'd3);
    check("R6 status read", rd_data[3:0], 8'h05 & 8'h0F);
    xfer(8'h00, 4'h0); mdl_acc(5'd3, 1'b0, 8'h00, 4'h0);
    xfer(8'h00, 4'h0); mdl_acc(5'd4, 1'b0, 8'h00, 4'h0);
    close_frame();
    rd_burst(5'd3, 2'd0, "R6 status cleared");
    // R6 write cannot set status, but clears it
    pulse_evt(4'hA);
    open_frame(1'b0, 2'd0, 5'd3); xfer(8'h0F, 4'h0); mdl_acc(5'd3, 1'b1, 8'h0F, 4'h0); close_frame();
    rd_burst(5'd3, 2'd0, "R6 write clears status");
    check("R6 status after write", m[3], 8'h00);

    // R7 mirror with clear at 9
    pulse_evt(4'h6);
    rd_burst(5'd9, 2'd0, "R7 mirror read");
    rd_burst(5'd3, 2'd0, "R7 source cleared");
    // R7 write to 8 ignored, mirror tracks 0
    open_frame(1'b0, 2'd0, 5'd0); xfer(8'h81, 4'h0); mdl_acc(5'd0, 1'b1, 8'h81, 4'h0); close_frame();
    open_frame(1'b0, 2'd0, 5'd8); xfer(8'h42, 4'h0); mdl_acc(5'd8, 1'b1, 8'h42, 4'h0); close_frame();
    rd_burst(5'd8, 2'd0, "R7 mirror of 0");

    // R8 event and clear in the same cycle
    pulse_evt(4'h3);
    open_frame(1'b1, 2'd0, 5'd3);
    check("R8 value before clear", rd_data, expv(5'd3));
    xfer(8'h00, 4'h4); mdl_acc(5'd3, 1'b0, 8'h00, 4'h4);
    close_frame();
    check("R8 model expects set", {4'h0, m[3][3:0]}, 8'h04);
    rd_burst(5'd3, 2'd0, "R8 set wins at 3");
    pulse_evt(4'h1);
    open_frame(1'b1, 2'd0, 5'd9);
    xfer(8'h00, 4'h8); mdl_acc(5'd9, 1'b0, 8'h00, 4'h8);
    close_frame();
    rd_burst(5'd9, 2'd0, "R8 set wins via mirror");

    // R1 extra bytes after the count are ignored
    open_frame(1'b0, 2'd0, 5'd10);
    xfer(8'h77, 4'h0); mdl_acc(5'd10, 1'b1, 8'h77, 4'h0);
    xfer(8'h99, 4'h0); xfer(8'h88, 4'h0);
    close_frame();
    rd_burst(5'd10, 2'd1, "R1 extra bytes ignored");

    // R9 abort mid-burst, next byte is a command
    open_frame(1'b0, 2'd3, 5'd5);
    xfer(8'h3C, 4'h0); mdl_acc(5'd5, 1'b1, 8'h3C, 4'h0);
    close_frame();
    open_frame(1'b1, 2'd1, 5'd5);
    check("R9 byte before abort", rd_data, 8'h3C);
    xfer(8'h00, 4'h0);
    check("R9 next untouched", rd_data, expv(5'd6));
    xfer(8'h00, 4'h0);
    close_frame();
    check("R10 idle after read", rd_data, 8'h00);

    finish_run();
  end
endmodule